// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block is the software-visible configuration register file of an SDRAM controller. It sits on a device-control-register bus and takes up only two register numbers there. The first register number is a pointer port. The second is a data window that reaches the internal register the pointer selects. Software first writes an internal offset into the pointer. It then reads or writes through the window.

The internal registers are:
- two error status words and an error address
- the controller configuration and a read-only status word
- refresh and power-management timers
- one control word per bank
- a timing register, ECC configuration and ECC error status

Each register keeps only its writable bits. The status word tracks edges on two configuration bits. A registered interrupt level follows whether the ECC error status is zero. The block does no SDRAM command sequencing and has no data path.

A bus access lasts one cycle. It consists of a select, a write strobe, a register number and write data. Read data appears on a register one cycle after a read select.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After reset the following values hold:
  - pointer, error words, error address, bank words, ECC configuration, ECC error status and status: 0
  - configuration: 0x00800000
  - refresh timer: 0x05F00000
  - power-management timer: 0x07C00000
  - ecc_irq_o: low
- R2: A write to register number 0x010 stores all 32 bits into the pointer. A read of 0x010 returns the pointer on rdata_o one cycle after the select. rdata_o holds its value in cycles with no read select.
- R3: The error status words at offsets 0x00 and 0x08 are write-one-to-clear: new value = old & ~wdata. Writing ones never sets a bit.
- R4: The error address at offset 0x10 stores written data unchanged.
- R5: A configuration write (offset 0x20) keeps only bits 31:21. When configuration bit 31 goes from 0 to 1, status bit 31 is cleared. When bit 31 goes from 1 to 0, status bit 31 is set.
- R6: When configuration bit 30 goes from 0 to 1, status bit 30 is set. When bit 30 goes from 1 to 0, status bit 30 is cleared.
- R7: The status word (offset 0x24) is read-only. Writes to it leave it unchanged.
- R8: Three registers apply a mask on write:
  - refresh timer (0x30) stores wdata & 0x3FF80000
  - power-management timer (0x34) stores (wdata & 0xF8000000) | 0x07C00000
  - ECC configuration (0x94) stores wdata & 0x00F00000
- R9: Bank control words sit at 0x40, 0x44, 0x48 and 0x4C, for banks 0 to 3. Each stores wdata & 0xFFDEE001 and is independent of the others.
- R10: The ECC error status (0x98) stores wdata & 0xFFF0F000. A non-zero masked write while the register is zero raises ecc_irq_o. A zero write while it is non-zero lowers ecc_irq_o. ecc_irq_o is registered and changes in the cycle after such a write.
- R11: Reading the timing offset 0x80, or any internal offset not listed above, returns 0xFFFFFFFF.
- R12: Register numbers other than 0x010 and 0x011 have no effect on a write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access select |
| we_i | input | 1 | Write strobe (1 = write, 0 = read) |
| regnum_i | input | 10 | Bus register number |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ecc_irq_o | output | 1 | ECC error interrupt level |

## Verification
The bench builds the block with its default parameters:
- four banks
- pointer port at 0x010 and data window at 0x011

With four banks, every bank word can be written with a distinct pattern, and leakage between banks shows up. Placing the two ports next to each other puts 0x012 within reach as a neighbouring foreign register number. The bench also steps the configuration through all four edge combinations of its two tracked bits. It drives the ECC error status through zero to non-zero and back, including a write whose bits are all masked away.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 10;

  localparam logic [DW-1:0] OFF_ERR0  = 32'h0000_0000;
  localparam logic [DW-1:0] OFF_ERR1  = 32'h0000_0008;
  localparam logic [DW-1:0] OFF_EADDR = 32'h0000_0010;
  localparam logic [DW-1:0] OFF_CFG   = 32'h0000_0020;
  localparam logic [DW-1:0] OFF_STAT  = 32'h0000_0024;
  localparam logic [DW-1:0] OFF_RTR   = 32'h0000_0030;
  localparam logic [DW-1:0] OFF_PMT   = 32'h0000_0034;
  localparam logic [DW-1:0] OFF_BANK0 = 32'h0000_0040;
  localparam logic [DW-1:0] OFF_BSTEP = 32'h0000_0004;
  localparam logic [DW-1:0] OFF_TIM   = 32'h0000_0080;
  localparam logic [DW-1:0] OFF_ECFG  = 32'h0000_0094;
  localparam logic [DW-1:0] OFF_EERR  = 32'h0000_0098;

  localparam logic [DW-1:0] MSK_CFG   = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_RTR   = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_PMT   = 32'hF800_0000;
  localparam logic [DW-1:0] FIX_PMT   = 32'h07C0_0000;
  localparam logic [DW-1:0] MSK_BANK  = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_ECFG  = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_EERR  = 32'hFFF0_F000;

  localparam logic [DW-1:0] RST_CFG   = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RTR   = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PMT   = 32'h07C0_0000;

  localparam logic [DW-1:0] RD_NONE   = 32'hFFFF_FFFF;

  localparam int unsigned CFG_EN_BIT  = 31;
  localparam int unsigned CFG_AUX_BIT = 30;
endpackage

// File: rtl/sdram_cfg_port.sv
module sdram_cfg_port
  import sdram_cfg_pkg::*;
#(
  parameter logic [AW-1:0] PTR_PORT  = 10'h010,
  parameter logic [AW-1:0] DATA_PORT = 10'h011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] regnum_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ptr_o,
  output logic          win_wr_o,
  output logic          win_rd_o,
  output logic          ptr_rd_o,
  output logic          any_rd_o
);
  logic hit_ptr, hit_win;

  assign hit_ptr  = sel_i && (regnum_i == PTR_PORT);
  assign hit_win  = sel_i && (regnum_i == DATA_PORT);
  assign win_wr_o = hit_win && we_i;
  assign win_rd_o = hit_win && !we_i;
  assign ptr_rd_o = hit_ptr && !we_i;
  assign any_rd_o = sel_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_o <= '0;
    else if (hit_ptr && we_i) ptr_o <= wdata_i;
  end
endmodule

// File: rtl/sdram_cfg_core.sv
module sdram_cfg_core
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         win_wr_i,
  input  logic [DW-1:0]                ptr_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                err0_o,
  output logic [DW-1:0]                err1_o,
  output logic [DW-1:0]                eaddr_o,
  output logic [DW-1:0]                cfg_o,
  output logic [DW-1:0]                stat_o,
  output logic [DW-1:0]                rtr_o,
  output logic [DW-1:0]                pmt_o,
  output logic [NUM_BANKS-1:0][DW-1:0] bank_o,
  output logic [DW-1:0]                ecfg_o,
  output logic [DW-1:0]                eerr_o,
  output logic                         irq_o
);
  logic [DW-1:0] cfg_nxt, eerr_nxt;
  logic en_rise, en_fall, aux_rise, aux_fall, wr_cfg, wr_eerr;

  assign wr_cfg   = win_wr_i && (ptr_i == OFF_CFG);
  assign wr_eerr  = win_wr_i && (ptr_i == OFF_EERR);
  assign cfg_nxt  = wdata_i & MSK_CFG;
  assign eerr_nxt = wdata_i & MSK_EERR;
  assign en_rise  = wr_cfg && !cfg_o[CFG_EN_BIT]  &&  cfg_nxt[CFG_EN_BIT];
  assign en_fall  = wr_cfg &&  cfg_o[CFG_EN_BIT]  && !cfg_nxt[CFG_EN_BIT];
  assign aux_rise = wr_cfg && !cfg_o[CFG_AUX_BIT] &&  cfg_nxt[CFG_AUX_BIT];
  assign aux_fall = wr_cfg &&  cfg_o[CFG_AUX_BIT] && !cfg_nxt[CFG_AUX_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err0_o  <= '0;
      err1_o  <= '0;
      eaddr_o <= '0;
      cfg_o   <= RST_CFG;
      rtr_o   <= RST_RTR;
      pmt_o   <= RST_PMT;
      ecfg_o  <= '0;
    end else if (win_wr_i) begin
      unique case (ptr_i)
        OFF_ERR0:  err0_o  <= err0_o & ~wdata_i;
        OFF_ERR1:  err1_o  <= err1_o & ~wdata_i;
        OFF_EADDR: eaddr_o <= wdata_i;
        OFF_CFG:   cfg_o   <= cfg_nxt;
        OFF_RTR:   rtr_o   <= wdata_i & MSK_RTR;
        OFF_PMT:   pmt_o   <= (wdata_i & MSK_PMT) | FIX_PMT;
        OFF_ECFG:  ecfg_o  <= wdata_i & MSK_ECFG;
        default: ;
      endcase
    end
  end

  // status follows configuration edges only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else begin
      if (en_rise)       stat_o[CFG_EN_BIT] <= 1'b0;
      else if (en_fall)  stat_o[CFG_EN_BIT] <= 1'b1;
      if (aux_rise)      stat_o[CFG_AUX_BIT] <= 1'b1;
      else if (aux_fall) stat_o[CFG_AUX_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eerr_o <= '0;
      irq_o  <= 1'b0;
    end else if (wr_eerr) begin
      eerr_o <= eerr_nxt;
      irq_o  <= |eerr_nxt;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [DW-1:0] BANK_OFF = OFF_BANK0 + OFF_BSTEP * b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              bank_o[b] <= '0;
      else if (win_wr_i && (ptr_i == BANK_OFF)) bank_o[b] <= wdata_i & MSK_BANK;
    end
  end
endmodule

// File: rtl/sdram_cfg_rdmux.sv
module sdram_cfg_rdmux
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic [DW-1:0]                ptr_i,
  input  logic [DW-1:0]                err0_i,
  input  logic [DW-1:0]                err1_i,
  input  logic [DW-1:0]                eaddr_i,
  input  logic [DW-1:0]                cfg_i,
  input  logic [DW-1:0]                stat_i,
  input  logic [DW-1:0]                rtr_i,
  input  logic [DW-1:0]                pmt_i,
  input  logic [NUM_BANKS-1:0][DW-1:0] bank_i,
  input  logic [DW-1:0]                ecfg_i,
  input  logic [DW-1:0]                eerr_i,
  output logic [DW-1:0]                rd_o
);
  logic [NUM_BANKS-1:0] bank_hit;
  logic [DW-1:0]        bank_val;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = (ptr_i == OFF_BANK0 + OFF_BSTEP * b);
  end

  always_comb begin
    bank_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) bank_val = bank_i[b];
    end
  end

  always_comb begin
    if (|bank_hit) rd_o = bank_val;
    else begin
      unique case (ptr_i)
        OFF_ERR0:  rd_o = err0_i;
        OFF_ERR1:  rd_o = err1_i;
        OFF_EADDR: rd_o = eaddr_i;
        OFF_CFG:   rd_o = cfg_i;
        OFF_STAT:  rd_o = stat_i;
        OFF_RTR:   rd_o = rtr_i;
        OFF_PMT:   rd_o = pmt_i;
        OFF_ECFG:  rd_o = ecfg_i;
        OFF_EERR:  rd_o = eerr_i;
        default:   rd_o = RD_NONE; // timing and unmapped offsets
      endcase
    end
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned   NUM_BANKS = 4,
  parameter logic [AW-1:0] PTR_PORT  = 10'h010,
  parameter logic [AW-1:0] DATA_PORT = 10'h011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] regnum_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ecc_irq_o
);
  logic [DW-1:0] ptr_q, err0_q, err1_q, eaddr_q, cfg_q, stat_q;
  logic [DW-1:0] rtr_q, pmt_q, ecfg_q, eerr_q, win_rd;
  logic [NUM_BANKS-1:0][DW-1:0] bank_q;
  logic win_wr, win_re, ptr_re, any_re;

  sdram_cfg_port #(.PTR_PORT(PTR_PORT), .DATA_PORT(DATA_PORT)) u_port (
    .clk_i, .rst_ni, .sel_i, .we_i, .regnum_i, .wdata_i,
    .ptr_o(ptr_q), .win_wr_o(win_wr), .win_rd_o(win_re),
    .ptr_rd_o(ptr_re), .any_rd_o(any_re)
  );

  sdram_cfg_core #(.NUM_BANKS(NUM_BANKS)) u_core (
    .clk_i, .rst_ni, .win_wr_i(win_wr), .ptr_i(ptr_q), .wdata_i,
    .err0_o(err0_q), .err1_o(err1_q), .eaddr_o(eaddr_q), .cfg_o(cfg_q),
    .stat_o(stat_q), .rtr_o(rtr_q), .pmt_o(pmt_q), .bank_o(bank_q),
    .ecfg_o(ecfg_q), .eerr_o(eerr_q), .irq_o(ecc_irq_o)
  );

  sdram_cfg_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rdmux (
    .ptr_i(ptr_q), .err0_i(err0_q), .err1_i(err1_q), .eaddr_i(eaddr_q),
    .cfg_i(cfg_q), .stat_i(stat_q), .rtr_i(rtr_q), .pmt_i(pmt_q),
    .bank_i(bank_q), .ecfg_i(ecfg_q), .eerr_i(eerr_q), .rd_o(win_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (ptr_re) rdata_o <= ptr_q;
    else if (win_re) rdata_o <= win_rd;
    else if (any_re) rdata_o <= '0;
  end
endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk
  import sdram_cfg_pkg::*;
#(
  parameter logic [AW-1:0] PTR_PORT  = 10'h010,
  parameter logic [AW-1:0] DATA_PORT = 10'h011
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          we_i,
  input logic [AW-1:0] regnum_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          ecc_irq_o,
  input logic [DW-1:0] ptr_i,
  input logic [DW-1:0] cfg_i,
  input logic [DW-1:0] stat_i,
  input logic [DW-1:0] eerr_i
);
  logic wwr, pwr;
  assign wwr = sel_i && we_i && (regnum_i == DATA_PORT);
  assign pwr = sel_i && we_i && (regnum_i == PTR_PORT);

  a_r2_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr |=> $stable(ptr_i));
  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i) |=> $stable(rdata_o));
  a_r7_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwr && ptr_i == OFF_STAT) |=> $stable(stat_i));
  a_r5_en_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwr && ptr_i == OFF_CFG && !cfg_i[CFG_EN_BIT] && wdata_i[CFG_EN_BIT])
    |=> !stat_i[CFG_EN_BIT]);
  a_r5_en_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwr && ptr_i == OFF_CFG && cfg_i[CFG_EN_BIT] && !wdata_i[CFG_EN_BIT])
    |=> stat_i[CFG_EN_BIT]);
  a_r6_aux_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwr && ptr_i == OFF_CFG && !cfg_i[CFG_AUX_BIT] && wdata_i[CFG_AUX_BIT])
    |=> stat_i[CFG_AUX_BIT]);
  a_r6_aux_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwr && ptr_i == OFF_CFG && cfg_i[CFG_AUX_BIT] && !wdata_i[CFG_AUX_BIT])
    |=> !stat_i[CFG_AUX_BIT]);
  a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wwr && ptr_i == OFF_EERR) |=> $stable(ecc_irq_o));
  a_r10_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_irq_o == (eerr_i != '0));
endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(.PTR_PORT(PTR_PORT), .DATA_PORT(DATA_PORT)) u_chk (
  .clk_i, .rst_ni, .sel_i, .we_i, .regnum_i, .wdata_i, .rdata_o, .ecc_irq_o,
  .ptr_i(ptr_q), .cfg_i(cfg_q), .stat_i(stat_q), .eerr_i(eerr_q)
);

// File: tb/sdram_cfg_regs_bench.sv
module sdram_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [9:0]  regnum = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  localparam logic [9:0] PP = 10'h010, DP = 10'h011;

  always #2 clk = ~clk;

  sdram_cfg_regs u_sdram_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .regnum_i(regnum),
    .wdata_i(wdata), .rdata_o(rdata), .ecc_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] rn, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; regnum = rn; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [9:0] rn, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; regnum = rn;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic wr_off(input logic [31:0] off, input logic [31:0] d);
    bus_wr(PP, off); bus_wr(DP, d);
  endtask

  task automatic rd_off(input logic [31:0] off, output logic [31:0] d);
    bus_wr(PP, off); bus_rd(DP, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq}, 32'd0);
    bus_rd(PP, v);       check("R1 ptr", v, 32'h0);
    rd_off(32'h00, v);   check("R1 err0", v, 32'h0);
    rd_off(32'h08, v);   check("R1 err1", v, 32'h0);
    rd_off(32'h10, v);   check("R1 eaddr", v, 32'h0);
    rd_off(32'h20, v);   check("R1 cfg", v, 32'h0080_0000);
    rd_off(32'h24, v);   check("R1 stat", v, 32'h0);
    rd_off(32'h30, v);   check("R1 rtr", v, 32'h05F0_0000);
    rd_off(32'h34, v);   check("R1 pmt", v, 32'h07C0_0000);
    rd_off(32'h94, v);   check("R1 ecfg", v, 32'h0);
    rd_off(32'h98, v);   check("R1 eerr", v, 32'h0);
    for (int b = 0; b < 4; b++) begin
      rd_off(32'h40 + 4 * b, v); check("R1 bank", v, 32'h0);
    end
  endtask

  task automatic t_pointer();
    logic [31:0] v;
    bus_wr(PP, 32'hDEAD_BEEF);
    bus_rd(PP, v); check("R2 ptr readback", v, 32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    check("R2 rdata hold", rdata, 32'hDEAD_BEEF);
    bus_rd(DP, v); check("R11 wide ptr unmapped", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c_addr();
    logic [31:0] v;
    wr_off(32'h00, 32'hFFFF_FFFF); rd_off(32'h00, v); check("R3 err0 no set", v, 32'h0);
    wr_off(32'h08, 32'hA5A5_A5A5); rd_off(32'h08, v); check("R3 err1 no set", v, 32'h0);
    wr_off(32'h10, 32'h1234_5678); rd_off(32'h10, v); check("R4 eaddr", v, 32'h1234_5678);
  endtask

  task automatic t_cfg_status();
    logic [31:0] v;
    wr_off(32'h20, 32'hFFFF_FFFF);
    rd_off(32'h20, v); check("R5 cfg mask", v, 32'hFFE0_0000);
    rd_off(32'h24, v); check("R5 R6 both rise", v, 32'h4000_0000);
    wr_off(32'h20, 32'h0000_0000);
    rd_off(32'h24, v); check("R5 R6 both fall", v, 32'h8000_0000);
    wr_off(32'h20, 32'h8000_0000);
    rd_off(32'h24, v); check("R5 en rise", v, 32'h0);
    wr_off(32'h20, 32'h4000_0000);
    rd_off(32'h24, v); check("R5 R6 en fall aux rise", v, 32'hC000_0000);
    wr_off(32'h20, 32'h4010_0000);
    rd_off(32'h24, v); check("R6 no edge", v, 32'hC000_0000);
    rd_off(32'h20, v); check("R5 low bits dropped", v, 32'h4000_0000);
  endtask

  task automatic t_status_ro();
    logic [31:0] v;
    wr_off(32'h24, 32'h1234_5678);
    rd_off(32'h24, v); check("R7 status ro", v, 32'hC000_0000);
    wr_off(32'h24, 32'h0);
    rd_off(32'h24, v); check("R7 status ro zero", v, 32'hC000_0000);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr_off(32'h30, 32'hFFFF_FFFF); rd_off(32'h30, v); check("R8 rtr", v, 32'h3FF8_0000);
    wr_off(32'h34, 32'h0);         rd_off(32'h34, v); check("R8 pmt zero", v, 32'h07C0_0000);
    wr_off(32'h34, 32'hFFFF_FFFF); rd_off(32'h34, v); check("R8 pmt ones", v, 32'hFFC0_0000);
    wr_off(32'h94, 32'hFFFF_FFFF); rd_off(32'h94, v); check("R8 ecfg", v, 32'h00F0_0000);
  endtask

  task automatic t_banks();
    logic [31:0] v;
    for (int b = 0; b < 4; b++)
      wr_off(32'h40 + 4 * b, 32'h1111_1111 * (b + 1) | 32'h1);
    for (int b = 0; b < 4; b++) begin
      rd_off(32'h40 + 4 * b, v);
      check("R9 bank", v, (32'h1111_1111 * (b + 1) | 32'h1) & 32'hFFDE_E001);
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr_off(32'h80, 32'h0);
    rd_off(32'h80, v); check("R11 timing", v, 32'hFFFF_FFFF);
    rd_off(32'h50, v); check("R11 unmapped 0x50", v, 32'hFFFF_FFFF);
    rd_off(32'h04, v); check("R11 unmapped 0x04", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_ecc();
    logic [31:0] v;
    wr_off(32'h98, 32'h0000_0FFF);
    check("R10 masked-out write keeps irq low", {31'd0, irq}, 32'd0);
    wr_off(32'h98, 32'hFFFF_FFFF);
    check("R10 irq raise", {31'd0, irq}, 32'd1);
    rd_off(32'h98, v); check("R10 eerr mask", v, 32'hFFF0_F000);
    wr_off(32'h98, 32'h0000_1000);
    check("R10 irq stays", {31'd0, irq}, 32'd1);
    rd_off(32'h98, v); check("R10 eerr value", v, 32'h0000_1000);
    wr_off(32'h98, 32'h0);
    check("R10 irq lower", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_foreign();
    logic [31:0] v;
    bus_wr(PP, 32'h10);
    bus_wr(10'h012, 32'h0000_0020);
    bus_wr(10'h00F, 32'h5555_5555);
    bus_rd(PP, v);      check("R12 ptr untouched", v, 32'h10);
    bus_rd(DP, v);      check("R12 eaddr untouched", v, 32'h1234_5678);
    bus_rd(10'h012, v); check("R12 foreign read zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_w1c_addr();
    t_cfg_status();
    t_status_ro();
    t_masks();
    t_banks();
    t_unmapped();
    t_ecc();
    t_foreign();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule